// File: doc/BRIEF.md
# Hashed MAC Address Filter Engine

This block decides whether a received frame should be taken in. It looks up the frame's 48-bit destination address in a hash table that sits in external memory. The caller gives it the destination address, a hash index that has already been computed, the byte address of the table, and three configuration bits: half-size table, forward on miss, and promiscuous. A single-cycle `start` pulse begins the lookup. The engine then walks a linear probe chain of 64-bit table entries. It fetches each entry as two 32-bit words through a read port. It finishes with a one-cycle `done` pulse, a lookup result and an accept action.

The read port is a request/response stream. A request is presented with `rd_valid` and `rd_addr`. It is taken in the cycle where `rd_ready` is also high. While `rd_ready` is low the request stays presented and `rd_addr` does not change, so memory can apply back-pressure for as long as it needs. The engine allows only one request in flight. The response comes back on `rsp_valid`/`rsp_data` at least one cycle after the request is taken. The response has no back-pressure, because the engine always waits for it.

Top module: `mac_hash_filter`

## Requirements
- R1: In full-size mode (`cfg_half`=0), the first request address is `tbl_base + hash_idx*8`. The sum wraps modulo 2^32.
- R2: In half-size mode (`cfg_half`=1), only the low 11 bits of `hash_idx` are used. The first request address is `tbl_base + (hash_idx & 0x7FF)*8`.
- R3: Each entry is read as two words. The first read is at the entry address and supplies entry bits 63:32. The second read is at the entry address + 4 and supplies bits 31:0.
- R4: An entry whose valid bit (bit 0) is clear ends the walk at once. The result is miss (`lookup_res`=0) and no further reads are made.
- R5: An entry is passed over if its skip bit (bit 1) is set, or if its bits 50:3 differ from the compare image. The walk then continues with the entry 8 bytes further on. A matching entry gives result match (`lookup_res`=1), and `hit_entry` holds that entry.
- R6: The compare image holds destination byte k at bits 8k+10 down to 8k+3, for k = 0..5. Byte 0 is `dst_addr[47:40]` and byte 5 is `dst_addr[7:0]`.
- R7: If 12 entries have been read without a match or an empty entry, the walk ends with result hop-exceeded (`lookup_res`=2) after exactly 24 reads.
- R8: The action codes are drop=0, accept=1 and accept-with-mark=2. The first rule that applies sets the action. Hop-exceeded gives accept. A match whose entry has its receive bit (bit 2) set gives accept-with-mark. A miss with `cfg_dflt_fwd` set gives accept-with-mark. Otherwise `cfg_promisc` set gives accept. In all other cases the action is drop.
- R9: Only one read is in flight at a time. A request that is not accepted stays on the port with the same address until `rd_ready` is high.
- R10: `done` is high for exactly one cycle. From then until the next accepted `start`, `lookup_res`, `action` and `hit_entry` do not change.
- R11: After reset, `busy`, `done` and `rd_valid` are low, `lookup_res` is miss and `action` is drop.
- R12: A `start` pulse while `busy` is high is ignored. The lookup in progress finishes with its own inputs and its own number of reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (taken only when idle) |
| dst_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| hash_idx | input | 13 | Precomputed hash index |
| tbl_base | input | 32 | Byte address of the hash table |
| cfg_half | input | 1 | Half-size table: use 11 index bits |
| cfg_dflt_fwd | input | 1 | Accept with mark on a miss |
| cfg_promisc | input | 1 | Accept frames that are otherwise dropped |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| lookup_res | output | 2 | 0 miss, 1 match, 2 hop-exceeded |
| action | output | 2 | 0 drop, 1 accept, 2 accept with mark |
| hit_entry | output | 64 | Last entry fetched (the matching one on a match) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data word |

## Verification
The hop-exceeded outcome is the hardest to reach from the ports. It needs a full chain of twelve entries that are valid but never match, with a correct entry placed just past the limit to show that the walk really stops there. The bench writes such chains into its memory model. It also builds chains that mix skipped entries with mismatched ones ahead of the hit. The memory model can hold `rd_ready` low in a pattern and add response latency, so each request is held across stalled cycles. A second `start` is sent into the middle of a walk to confirm that it has no effect.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  typedef enum logic [1:0] {
    RES_MISS  = 2'd0,
    RES_MATCH = 2'd1,
    RES_HOPX  = 2'd2
  } lookup_res_e;

  typedef enum logic [1:0] {
    ACT_DROP   = 2'd0,
    ACT_ACCEPT = 2'd1,
    ACT_MARK   = 2'd2
  } action_e;

  typedef enum logic [1:0] {
    VERDICT_EMPTY = 2'd0,
    VERDICT_PASS  = 2'd1,
    VERDICT_HIT   = 2'd2
  } verdict_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_JUDGE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/mhf_slot_addr.sv
module mhf_slot_addr #(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 13,
  parameter int HALF_IDX_W = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic              half,
  output logic [ADDR_W-1:0] first_addr
);
  localparam int SLOT_SHIFT = 3;
  localparam int OFS_W      = IDX_W + SLOT_SHIFT;

  logic [IDX_W-1:0] eff_idx;
  logic [OFS_W-1:0] byte_ofs;

  generate
    if (HALF_IDX_W < IDX_W) begin : g_halvable
      assign eff_idx = half ? {{(IDX_W-HALF_IDX_W){1'b0}}, idx[HALF_IDX_W-1:0]} : idx;
    end else begin : g_full_only
      assign eff_idx = idx;
    end
  endgenerate

  assign byte_ofs   = {eff_idx, {SLOT_SHIFT{1'b0}}};
  assign first_addr = base + ADDR_W'(byte_ofs);
endmodule

// File: rtl/mhf_cmp_image.sv
module mhf_cmp_image #(
  parameter int ENTRY_W   = 64,
  parameter int IMG_SHIFT = 3
) (
  input  logic [47:0]        dst,
  output logic [ENTRY_W-1:0] image
);
  localparam int NBYTES = 6;

  always_comb begin
    image = '0;
    for (int k = 0; k < NBYTES; k++) begin
      image[IMG_SHIFT + 8*k +: 8] = dst[47 - 8*k -: 8];
    end
  end
endmodule

// File: rtl/mhf_entry_judge.sv
module mhf_entry_judge
  import mhf_pkg::*;
#(
  parameter int              ENTRY_W   = 64,
  parameter logic [63:0]     ADDR_MASK = 64'h0007_FFFF_FFFF_FFF8,
  parameter int              VALID_BIT = 0,
  parameter int              SKIP_BIT  = 1,
  parameter int              RECV_BIT  = 2
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [ENTRY_W-1:0] image,
  output verdict_e           verdict,
  output logic               recv
);
  logic addr_eq;

  assign addr_eq = ((entry & ADDR_MASK[ENTRY_W-1:0]) == image);
  assign recv    = entry[RECV_BIT];

  always_comb begin
    if (!entry[VALID_BIT])
      verdict = VERDICT_EMPTY;
    else if (entry[SKIP_BIT] || !addr_eq)
      verdict = VERDICT_PASS;
    else
      verdict = VERDICT_HIT;
  end
endmodule

// File: rtl/mhf_action_map.sv
module mhf_action_map
  import mhf_pkg::*;
(
  input  lookup_res_e res,
  input  logic        recv,
  input  logic        dflt_fwd,
  input  logic        promisc,
  output action_e     act
);
  always_comb begin
    if (res == RES_HOPX)
      act = ACT_ACCEPT;
    else if (res == RES_MATCH && recv)
      act = ACT_MARK;
    else if (res == RES_MISS && dflt_fwd)
      act = ACT_MARK;
    else if (promisc)
      act = ACT_ACCEPT;
    else
      act = ACT_DROP;
  end
endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter
  import mhf_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          IDX_W      = 13,
  parameter int          HALF_IDX_W = 11,
  parameter int          HOP_LIMIT  = 12,
  parameter int          IMG_SHIFT  = 3,
  parameter logic [63:0] ADDR_MASK  = 64'h0007_FFFF_FFFF_FFF8,
  parameter int          VALID_BIT  = 0,
  parameter int          SKIP_BIT   = 1,
  parameter int          RECV_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [47:0]       dst_addr,
  input  logic [IDX_W-1:0]  hash_idx,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic              cfg_half,
  input  logic              cfg_dflt_fwd,
  input  logic              cfg_promisc,
  output logic              busy,
  output logic              done,
  output logic [1:0]        lookup_res,
  output logic [1:0]        action,
  output logic [63:0]       hit_entry,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data
);
  localparam int          ENTRY_W    = 64;
  localparam int          WORD_W     = 32;
  localparam int          HOP_W      = $clog2(HOP_LIMIT + 1);
  localparam logic [ADDR_W-1:0] SLOT_BYTES = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(4);
  localparam logic [HOP_W-1:0]  LAST_HOP   = HOP_W'(HOP_LIMIT - 1);

  walk_state_e        state_q;
  logic [ADDR_W-1:0]  slot_q;
  logic               low_half_q;
  logic [HOP_W-1:0]   hop_q;
  logic [47:0]        dst_q;
  logic               dflt_q, prom_q;
  logic [ENTRY_W-1:0] entry_q;
  lookup_res_e        res_q;
  action_e            act_q;
  logic               done_q;

  logic [ADDR_W-1:0]  first_addr;
  logic [ENTRY_W-1:0] image;
  verdict_e           verdict;
  logic               entry_recv;
  lookup_res_e        fin_res;
  logic               fin_now;
  action_e            fin_act;

  mhf_slot_addr #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HALF_IDX_W(HALF_IDX_W)
  ) u_slot (
    .base(tbl_base), .idx(hash_idx), .half(cfg_half), .first_addr(first_addr)
  );

  mhf_cmp_image #(
    .ENTRY_W(ENTRY_W), .IMG_SHIFT(IMG_SHIFT)
  ) u_image (
    .dst(dst_q), .image(image)
  );

  mhf_entry_judge #(
    .ENTRY_W(ENTRY_W), .ADDR_MASK(ADDR_MASK),
    .VALID_BIT(VALID_BIT), .SKIP_BIT(SKIP_BIT), .RECV_BIT(RECV_BIT)
  ) u_judge (
    .entry(entry_q), .image(image), .verdict(verdict), .recv(entry_recv)
  );

  // Decide, in the judge state, whether the walk ends here and how.
  always_comb begin
    fin_now = 1'b0;
    fin_res = RES_MISS;
    if (state_q == ST_JUDGE) begin
      unique case (verdict)
        VERDICT_EMPTY: begin fin_now = 1'b1; fin_res = RES_MISS;  end
        VERDICT_HIT:   begin fin_now = 1'b1; fin_res = RES_MATCH; end
        default: begin
          if (hop_q == LAST_HOP) begin
            fin_now = 1'b1;
            fin_res = RES_HOPX;
          end
        end
      endcase
    end
  end

  mhf_action_map u_action (
    .res(fin_res), .recv(entry_recv), .dflt_fwd(dflt_q),
    .promisc(prom_q), .act(fin_act)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      slot_q     <= '0;
      low_half_q <= 1'b0;
      hop_q      <= '0;
      dst_q      <= '0;
      dflt_q     <= 1'b0;
      prom_q     <= 1'b0;
      entry_q    <= '0;
      res_q      <= RES_MISS;
      act_q      <= ACT_DROP;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            slot_q     <= first_addr;
            low_half_q <= 1'b0;
            hop_q      <= '0;
            dst_q      <= dst_addr;
            dflt_q     <= cfg_dflt_fwd;
            prom_q     <= cfg_promisc;
            state_q    <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rd_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (!low_half_q) begin
              entry_q[ENTRY_W-1:WORD_W] <= rsp_data;
              low_half_q <= 1'b1;
              state_q    <= ST_REQ;
            end else begin
              entry_q[WORD_W-1:0] <= rsp_data;
              state_q <= ST_JUDGE;
            end
          end
        end
        ST_JUDGE: begin
          if (fin_now) begin
            res_q   <= fin_res;
            act_q   <= fin_act;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            hop_q      <= hop_q + HOP_W'(1);
            slot_q     <= slot_q + SLOT_BYTES;
            low_half_q <= 1'b0;
            state_q    <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign lookup_res = res_q;
  assign action     = act_q;
  assign hit_entry  = entry_q;
  assign rd_valid   = (state_q == ST_REQ);
  assign rd_addr    = low_half_q ? (slot_q + WORD_BYTES) : slot_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int ADDR_W    = 32,
  parameter int HOP_LIMIT = 12,
  parameter int VALID_BIT = 0,
  parameter int SKIP_BIT  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        lookup_res,
  input logic [1:0]        action,
  input logic [63:0]       hit_entry,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rsp_valid
);
  localparam int MAX_READS = 2 * HOP_LIMIT;
  localparam int CNT_W     = $clog2(MAX_READS + 2);

  logic [CNT_W-1:0] reads_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reads_q <= '0;
    end else begin
      if (start && !busy) reads_q <= '0;
      else if (rd_valid && rd_ready && reads_q != {CNT_W{1'b1}}) reads_q <= reads_q + CNT_W'(1);
      assert_read_bound_R7: assert (reads_q <= CNT_W'(MAX_READS))
        else $error("walk exceeded the read budget");
    end
  end

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rd_valid);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(lookup_res) && $stable(action) && $stable(hit_entry)));

  assert_idle_at_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  assert_hopx_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lookup_res == 2'd2) |-> (action == 2'd1));

  assert_match_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lookup_res == 2'd1) |-> (hit_entry[VALID_BIT] && !hit_entry[SKIP_BIT]));

  assert_miss_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && lookup_res == 2'd0) |-> !hit_entry[VALID_BIT]);
endmodule

bind mac_hash_filter mhf_checker #(
  .ADDR_W(ADDR_W), .HOP_LIMIT(HOP_LIMIT), .VALID_BIT(VALID_BIT), .SKIP_BIT(SKIP_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .lookup_res(lookup_res), .action(action), .hit_entry(hit_entry),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rsp_valid(rsp_valid)
);

// File: tb/mac_hash_filter_tb_top.sv
module mac_hash_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h4000_0000;
  localparam logic [63:0] FV = 64'h1, FS = 64'h2, FR = 64'h4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [47:0] dst_addr = '0;
  logic [12:0] hash_idx = '0;
  logic [31:0] tbl_base = BASE;
  logic cfg_half = 1'b0, cfg_dflt_fwd = 1'b0, cfg_promisc = 1'b0;
  logic busy, done, rd_valid, rd_ready, rsp_valid;
  logic [1:0] lookup_res, action;
  logic [63:0] hit_entry;
  logic [31:0] rd_addr, rsp_data;

  int errors = 0, checks = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];
  logic [31:0] req_log [0:63];
  int nreq = 0;
  int lat = 0;
  bit stall = 0;
  int cyc = 0;

  logic [1:0]  got_res, got_act;
  logic [63:0] got_entry;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_hash_filter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dst_addr(dst_addr), .hash_idx(hash_idx),
    .tbl_base(tbl_base), .cfg_half(cfg_half), .cfg_dflt_fwd(cfg_dflt_fwd),
    .cfg_promisc(cfg_promisc), .busy(busy), .done(done), .lookup_res(lookup_res),
    .action(action), .hit_entry(hit_entry), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // Memory model: everything is driven at the falling edge.
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [31:0] pa = '0;
    rd_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          rsp_valid = 1'b1;
          rsp_data  = mem[pa[11:2]];
          pend = 0;
        end else cnt--;
      end
      rd_ready = stall ? ((cyc % 3) == 0) : 1'b1;
      if (rd_valid && rd_ready) begin
        pend = 1; cnt = lat; pa = rd_addr;
        if (nreq < 64) req_log[nreq] = rd_addr;
        nreq++;
      end
    end
  end

  function automatic logic [63:0] img(input logic [47:0] d);
    return {13'b0, d[7:0], d[15:8], d[23:16], d[31:24], d[39:32], d[47:40], 3'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic put_entry(input logic [31:0] a, input logic [63:0] e);
    logic [31:0] a4;
    a4 = a + 32'd4;
    mem[a[11:2]]  = e[63:32];
    mem[a4[11:2]] = e[31:0];
  endtask

  task automatic launch(input logic [47:0] d, input logic [12:0] ix, input bit h, f, p);
    @(negedge clk);
    dst_addr = d; hash_idx = ix; cfg_half = h; cfg_dflt_fwd = f; cfg_promisc = p;
    nreq = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(done, "R10 done within time", {63'b0, done}, 64'h1);
    got_res = lookup_res; got_act = action; got_entry = hit_entry;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !rd_valid, "R11 idle outputs", {61'b0, busy, done, rd_valid}, 64'h0);
    chk(lookup_res == 2'd0 && action == 2'd0, "R11 result/action", {60'b0, lookup_res, action}, 64'h0);
  endtask

  task automatic t_first_match();
    logic [47:0] d = 48'h0A1B_2C3D_4E5F;
    logic [31:0] a = BASE + 32'h1ABC * 8;
    clear_mem();
    put_entry(a, img(d) | FV | FR);
    launch(d, 13'h1ABC, 0, 0, 0);
    wait_done();
    chk(req_log[0] == a, "R1 first address", req_log[0], a);
    chk(req_log[1] == a + 4, "R3 second word address", req_log[1], a + 4);
    chk(nreq == 2, "R3 two reads", nreq, 2);
    chk(got_res == 2'd1, "R6 image match", got_res, 1);
    chk(got_act == 2'd2, "R8 match+receive marks", got_act, 2);
    chk(got_entry == (img(d) | FV | FR), "R3 word order in hit_entry", got_entry, img(d) | FV | FR);
  endtask

  task automatic t_half();
    logic [47:0] d = 48'hFFEE_DDCC_BBAA;
    logic [31:0] a = BASE + 32'h2BC * 8;
    clear_mem();
    put_entry(a, img(d) | FV);
    launch(d, 13'h1ABC, 1, 0, 0);
    wait_done();
    chk(req_log[0] == a, "R2 half-size index mask", req_log[0], a);
    chk(got_res == 2'd1, "R2 match in half mode", got_res, 1);
    chk(got_act == 2'd0, "R8 match without receive drops", got_act, 0);
    launch(d, 13'h1ABC, 1, 0, 1);
    wait_done();
    chk(got_act == 2'd1, "R8 promiscuous accepts", got_act, 1);
  endtask

  task automatic t_chain();
    logic [47:0] d = 48'h0102_0304_0506;
    logic [31:0] a = BASE + 32'h40 * 8;
    clear_mem();
    put_entry(a,      img(d) | FV | FS | FR);
    put_entry(a + 8,  img(48'h0102_0304_0507) | FV | FR);
    put_entry(a + 16, img(d) | FV);
    launch(d, 13'h40, 0, 1, 1);
    wait_done();
    chk(nreq == 6, "R5 three entries read", nreq, 6);
    chk(req_log[2] == a + 8 && req_log[4] == a + 16, "R5 step of 8 bytes", req_log[4], a + 16);
    chk(got_res == 2'd1, "R5 match after skip and mismatch", got_res, 1);
    chk(got_act == 2'd1, "R8 match no receive with promisc", got_act, 1);
  endtask

  task automatic t_miss();
    logic [47:0] d = 48'hA0A1_A2A3_A4A5;
    logic [31:0] a = BASE + 32'h10 * 8;
    clear_mem();
    put_entry(a + 8, img(d) | FV | FR);
    launch(d, 13'h10, 0, 1, 0);
    wait_done();
    chk(nreq == 2, "R4 walk stops at empty entry", nreq, 2);
    chk(got_res == 2'd0, "R4 miss result", got_res, 0);
    chk(got_act == 2'd2, "R8 miss with default forward", got_act, 2);
    launch(d, 13'h10, 0, 0, 0);
    wait_done();
    chk(got_act == 2'd0, "R8 miss drops", got_act, 0);
    launch(d, 13'h10, 0, 0, 1);
    wait_done();
    chk(got_act == 2'd1, "R8 miss promiscuous accepts", got_act, 1);
  endtask

  task automatic t_hop();
    logic [47:0] d = 48'h5555_6666_7777;
    logic [31:0] a = BASE + 32'h100 * 8;
    clear_mem();
    for (int i = 0; i < 12; i++) put_entry(a + 8*i, img(d ^ 48'h1) | FV | FR);
    put_entry(a + 96, img(d) | FV | FR);
    launch(d, 13'h100, 0, 0, 0);
    wait_done();
    chk(nreq == 24, "R7 read count at hop limit", nreq, 24);
    chk(got_res == 2'd2, "R7 hop-exceeded result", got_res, 2);
    chk(got_act == 2'd1, "R8 hop-exceeded accepts", got_act, 1);
  endtask

  task automatic t_stall();
    logic [47:0] d = 48'h1234_5678_9ABC;
    logic [31:0] a = BASE + 32'h7 * 8;
    clear_mem();
    put_entry(a,     img(d) | FS | FV);
    put_entry(a + 8, img(d) | FV | FR);
    stall = 1; lat = 3;
    launch(d, 13'h7, 0, 0, 0);
    wait_done();
    stall = 0; lat = 0;
    chk(nreq == 4, "R9 reads under back-pressure", nreq, 4);
    chk(req_log[3] == a + 12, "R9 address order kept", req_log[3], a + 12);
    chk(got_res == 2'd1 && got_act == 2'd2, "R9 result under back-pressure", {got_res, got_act}, 4'b0110);
  endtask

  task automatic t_hold_and_busy_start();
    logic [47:0] d = 48'h0102_0304_0506;
    logic [31:0] a = BASE + 32'h40 * 8;
    clear_mem();
    put_entry(a,      img(d) | FV | FS);
    put_entry(a + 8,  img(48'h0) | FV);
    put_entry(a + 16, img(d) | FV | FR);
    launch(d, 13'h40, 0, 0, 0);
    repeat (3) @(negedge clk);
    dst_addr = 48'hDEAD_BEEF_0000; hash_idx = 13'h3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    chk(nreq == 6 && req_log[0] == a, "R12 start while busy ignored", nreq, 6);
    chk(got_res == 2'd1 && got_act == 2'd2, "R12 original lookup result", {got_res, got_act}, 4'b0110);
    @(negedge clk);
    chk(!done, "R10 done single cycle", {63'b0, done}, 0);
    repeat (5) @(negedge clk);
    chk(lookup_res == got_res && action == got_act && hit_entry == got_entry,
        "R10 outputs held after done", hit_entry, got_entry);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_match();
    t_half();
    t_chain();
    t_miss();
    t_hop();
    t_stall();
    t_hold_and_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule